// File: doc/BRIEF.md
# Accumulator Arithmetic/Logic Unit with Equality Flag

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle it takes the accumulator byte, one source operand already chosen by the surrounding datapath, and a 3-bit function code. From these it forms an 8-bit result at once, with no clock involved. It also raises a write strobe whenever the accumulator should take that result.

One piece of state lives inside: a single equality flag. Only the compare function changes it, on the clock edge after the compare is presented. All other functions leave it untouched. The enclosing processor reads this flag to decide conditional branches.

There is no increment, no right shift, no AND, and no carry or overflow output. Software builds an increment from an add of the constant 1. Decrement, invert and shift-left work on the source operand, not on the accumulator. Function codes: 0 add, 1 subtract, 2 decrement, 3 OR, 4 invert, 5 shift-left, 6 compare, 7 reserved.

Top module: `acc_alu`

## Requirements
- R1: With function 0, `result` is (`acc_in` + `opnd_in`) mod 256 and `res_wr` is 1.
- R2: With function 1, `result` is (`acc_in` − `opnd_in`) mod 256 and `res_wr` is 1.
- R3: With function 2, `result` is (`opnd_in` − 1) mod 256, whatever `acc_in` holds, and `res_wr` is 1.
- R4: With function 3, `result` is the bitwise OR of `acc_in` and `opnd_in`, and `res_wr` is 1.
- R5: With function 4, `result` is the bitwise complement of `opnd_in`, and `res_wr` is 1.
- R6: With function 5, `result` is `opnd_in` shifted one place toward bit 7, with bit 0 set to 0 and the old bit 7 lost; `res_wr` is 1.
- R7: With function 6, `res_wr` is 0, `flag_upd` is 1, and `result` shows the difference (`acc_in` − `opnd_in`) mod 256. At the next rising clock edge, `eq_flag` becomes 1 if `acc_in` equals `opnd_in` and 0 if it does not.
- R8: While the function code is not 6, `flag_upd` is 0 and `eq_flag` keeps its value across clock edges.
- R9: The reserved function code 7 gives `result` = 0 with both `res_wr` and `flag_upd` at 0.
- R10: While `rst_n` is low, `eq_flag` reads 0. Release of reset takes effect in step with the clock.
- R11: An increment comes from function 0 with `opnd_in` = 1, and it wraps: 0xFF gives 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| func | input | 3 | Function code (0 add … 6 compare, 7 reserved) |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Selected source operand |
| result | output | 8 | Combinational result |
| res_wr | output | 1 | Accumulator write strobe |
| flag_upd | output | 1 | High while a compare is presented |
| eq_flag | output | 1 | Registered equality flag |

## Verification
The clocked assertions assume that the function code and operands are steady around each rising edge. They also assume no compare is presented while the internal reset is still active. The stimulus meets both: it changes inputs only on falling edges, and it starts operations a few cycles after reset is released. Random codes cover all eight values, including the reserved one. Random operands are mixed with directed pairs at the wrap points (0x00, 0x7F, 0x80, 0xFF), with equal and unequal compare pairs, and with runs of non-compare functions placed between compares.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int FN_W = 3;

  typedef enum logic [FN_W-1:0] {
    FN_ADD  = 3'd0,
    FN_SUB  = 3'd1,
    FN_DEC  = 3'd2,
    FN_OR   = 3'd3,
    FN_INV  = 3'd4,
    FN_SHL  = 3'd5,
    FN_CMP  = 3'd6,
    FN_RSVD = 3'd7
  } alu_fn_e;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 8
) (
  input  alu_pkg::alu_fn_e fn,
  input  logic [W-1:0]     acc,
  input  logic [W-1:0]     opnd,
  output logic [W-1:0]     sum,
  output logic             sum_zero
);
  logic [W-1:0] add_a;
  logic [W-1:0] add_b;
  logic         add_c;

  // One shared adder: subtract/compare by complement-plus-one,
  // decrement by adding all ones to the operand.
  always_comb begin
    add_a = '0;
    add_b = '0;
    add_c = 1'b0;
    case (fn)
      alu_pkg::FN_ADD: begin add_a = acc;  add_b = opnd;  end
      alu_pkg::FN_SUB,
      alu_pkg::FN_CMP: begin add_a = acc;  add_b = ~opnd; add_c = 1'b1; end
      alu_pkg::FN_DEC: begin add_a = opnd; add_b = '1;    end
      default:         begin add_a = '0;   add_b = '0;    end
    endcase
  end

  assign sum      = add_a + add_b + {{(W-1){1'b0}}, add_c};
  assign sum_zero = (sum == '0);
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops #(
  parameter int W = 8
) (
  input  alu_pkg::alu_fn_e fn,
  input  logic [W-1:0]     acc,
  input  logic [W-1:0]     opnd,
  output logic [W-1:0]     bits
);
  always_comb begin
    case (fn)
      alu_pkg::FN_OR:  bits = acc | opnd;
      alu_pkg::FN_INV: bits = ~opnd;
      alu_pkg::FN_SHL: bits = {opnd[W-2:0], 1'b0};
      default:         bits = '0;
    endcase
  end
endmodule

// File: rtl/alu_eq_flag.sv
module alu_eq_flag #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic eq,
  output logic flag
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q;
  logic                   flag_d;
  logic                   flag_q;

  // Reset asserts at once, releases after SYNC_STAGES edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q = rst_pipe[SYNC_STAGES-1];

  always_comb begin
    flag_d = flag_q;
    if (upd) flag_d = eq;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R7: a compare lands its equality outcome on the next edge
  a_r7_flag_takes_eq: assert property (@(posedge clk) disable iff (!rst_q)
    upd |=> (flag_q == $past(eq)));

  // R8: no compare, no change
  a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_q)
    !upd |=> $stable(flag_q));
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [alu_pkg::FN_W-1:0]    func,
  input  logic [DATA_W-1:0]           acc_in,
  input  logic [DATA_W-1:0]           opnd_in,
  output logic [DATA_W-1:0]           result,
  output logic                        res_wr,
  output logic                        flag_upd,
  output logic                        eq_flag
);
  alu_pkg::alu_fn_e fn;
  logic [DATA_W-1:0] arith_res;
  logic [DATA_W-1:0] logic_res;
  logic              diff_zero;

  assign fn = alu_pkg::alu_fn_e'(func);

  alu_adder #(.W(DATA_W)) u_adder (
    .fn(fn), .acc(acc_in), .opnd(opnd_in),
    .sum(arith_res), .sum_zero(diff_zero)
  );

  alu_bitops #(.W(DATA_W)) u_bitops (
    .fn(fn), .acc(acc_in), .opnd(opnd_in), .bits(logic_res)
  );

  always_comb begin
    result   = '0;
    res_wr   = 1'b0;
    flag_upd = 1'b0;
    case (fn)
      alu_pkg::FN_ADD, alu_pkg::FN_SUB, alu_pkg::FN_DEC: begin
        result = arith_res;
        res_wr = 1'b1;
      end
      alu_pkg::FN_OR, alu_pkg::FN_INV, alu_pkg::FN_SHL: begin
        result = logic_res;
        res_wr = 1'b1;
      end
      alu_pkg::FN_CMP: begin
        result   = arith_res;
        flag_upd = 1'b1;
      end
      default: begin
        result = '0;
      end
    endcase
  end

  alu_eq_flag #(.SYNC_STAGES(2)) u_flag (
    .clk(clk), .rst_n(rst_n), .upd(flag_upd), .eq(diff_zero), .flag(eq_flag)
  );

  always_comb begin
    // R7: compare never writes the accumulator, and strobes are exclusive
    a_r7_cmp_no_write: assert (!(res_wr && flag_upd));
    // R9: reserved code stays silent
    if (func == 3'd7)
      a_r9_rsvd_quiet: assert (result == '0 && !res_wr && !flag_upd);
  end
endmodule

// File: tb/test_acc_alu.sv
module test_acc_alu;
  logic       clk;
  logic       rst_n;
  logic [2:0] func;
  logic [7:0] acc_in;
  logic [7:0] opnd_in;
  logic [7:0] result;
  logic       res_wr;
  logic       flag_upd;
  logic       eq_flag;

  int checks;
  int errors;
  bit exp_flag;
  bit done;

  acc_alu i_acc_alu (
    .clk(clk), .rst_n(rst_n), .func(func), .acc_in(acc_in), .opnd_in(opnd_in),
    .result(result), .res_wr(res_wr), .flag_upd(flag_upd), .eq_flag(eq_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] model_res(input logic [2:0] f, input logic [7:0] a, input logic [7:0] o);
    case (f)
      3'd0: return a + o;
      3'd1: return a - o;
      3'd2: return o - 8'd1;
      3'd3: return a | o;
      3'd4: return ~o;
      3'd5: return {o[6:0], 1'b0};
      3'd6: return a - o;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] f);
    case (f)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] f, input logic [7:0] a, input logic [7:0] o);
    @(negedge clk);
    func = f; acc_in = a; opnd_in = o;
    #1;
    check(req_of(f), {24'h0, result}, {24'h0, model_res(f, a, o)});
    check(req_of(f), {31'h0, res_wr}, {31'h0, (f <= 3'd5)});
    check((f == 3'd6) ? "R7" : "R8", {31'h0, flag_upd}, {31'h0, (f == 3'd6)});
    @(posedge clk);
    if (f == 3'd6) exp_flag = (a == o);
    #1;
    check((f == 3'd6) ? "R7" : "R8", {31'h0, eq_flag}, {31'h0, exp_flag});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; exp_flag = 1'b0; done = 1'b0;
    rst_n = 1'b0; func = 3'd0; acc_in = 8'h00; opnd_in = 8'h00;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R10", {31'h0, eq_flag}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", {31'h0, eq_flag}, 32'h0);

    // directed corners
    apply(3'd0, 8'hFF, 8'h01);   // R11 increment wraps
    check("R11", {24'h0, result}, 32'h00);
    apply(3'd0, 8'h7F, 8'h01);   // R11
    apply(3'd0, 8'h80, 8'h80);   // R1 wrap
    apply(3'd1, 8'h00, 8'h01);   // R2 borrow wrap
    apply(3'd2, 8'h55, 8'h00);   // R3 operand 0 -> FF, acc ignored
    apply(3'd2, 8'hAA, 8'h00);   // R3 acc changed, same result
    apply(3'd3, 8'hF0, 8'h0F);   // R4
    apply(3'd4, 8'h00, 8'hA5);   // R5
    apply(3'd5, 8'h00, 8'hFF);   // R6 bit 7 dropped
    apply(3'd5, 8'h00, 8'h80);   // R6
    apply(3'd6, 8'h3C, 8'h3C);   // R7 equal -> 1
    apply(3'd0, 8'h01, 8'h02);   // R8 hold after set
    apply(3'd7, 8'h3C, 8'h3C);   // R9 and R8
    apply(3'd6, 8'h3C, 8'h3D);   // R7 unequal -> 0
    apply(3'd1, 8'h09, 8'h09);   // R8 zero result does not touch flag
    apply(3'd6, 8'h00, 8'h00);   // R7
    apply(3'd7, 8'hFF, 8'h01);   // R9

    for (int i = 0; i < 400; i++) begin
      logic [2:0] f;
      logic [7:0] a;
      logic [7:0] o;
      f = 3'($urandom_range(0, 7));
      a = 8'($urandom);
      o = ($urandom_range(0, 3) == 0) ? a : 8'($urandom);
      apply(f, a, o);
    end

    finish_run();
  end
endmodule